// File: doc/BRIEF.md
# Buffered Serial Transmit/Receive Core

This core sends and receives asynchronous serial characters on two lines, `txd` and `rxd`. One data location on a simple strobe bus serves both directions: a write strobe hands a byte to the transmitter, and the read data always shows the last character the receiver assembled. A 12-bit divisor and a speed-select input set the bit rate. The bit time is 16 × (divisor + 1) clock cycles normally, or 8 × (divisor + 1) in the fast mode. Characters carry 5 to 8 data bits.

The transmitter has two stages. A holding register takes the written byte, and the serialiser pulls it from there whenever it is idle. This lets software queue the next character while the current one is still on the line. The `dre` output reports that the holding register is free. The receiver waits for a falling edge, confirms the start bit half a bit later, and samples each later bit in its middle. It then places the character in the receive register, sets `rxc`, and records whether the stop bit was valid.

Top module: `uart_core`

## Requirements
- R1: A write strobe loads the transmit side only. `data_rdata` keeps showing the receive register whether or not a write occurs.
- R2: A write while `dre` is low is discarded. The held byte is kept and sent, and no extra frame appears for the discarded write.
- R3: `dre` is 1 after reset and drops on an accepted write. With `tx_en` high and the serialiser idle, the held byte moves to the serialiser and `dre` returns to 1. With `tx_en` low, the byte stays held and `txd` stays high.
- R4: A frame is one low start bit, then the data bits least significant first, then one high stop bit. The line idles high, including out of reset.
- R5: `char_size` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. The transmitter sends only that many low bits of the written byte and ignores the rest.
- R6: The receiver returns the unused upper bits of a character as zero. After reset `data_rdata` is 0.
- R7: With `dbl_speed` low, one bit lasts 16 × (divisor + 1) clock cycles.
- R8: With `dbl_speed` high, one bit lasts 8 × (divisor + 1) clock cycles.
- R9: Writing the divisor restarts the prescaler at the new value at once. The first bit of a frame started right after the write is not lengthened by the old count.
- R10: A completed reception sets `rxc` and updates `data_rdata`. A read strobe clears `rxc`. `rxc` is 0 after reset.
- R11: A stop bit sampled low sets `frame_err` together with the character. A stop bit sampled high clears it.
- R12: A low pulse on `rxd` shorter than half a bit does not start a reception.
- R13: While `rx_en` is low, frames on `rxd` leave `rxc` and `data_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr | input | 1 | Divisor write strobe |
| div_val | input | 12 | New divisor value |
| dbl_speed | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| char_size | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| data_wr | input | 1 | Data write strobe (to transmit holding register) |
| data_wdata | input | 8 | Data to transmit |
| data_rd | input | 1 | Data read strobe (clears `rxc`) |
| data_rdata | output | 8 | Receive register contents |
| dre | output | 1 | Transmit holding register empty |
| rxc | output | 1 | Receive complete |
| frame_err | output | 1 | Stop bit of the held character was low |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench writes a second byte into a full holding register. A core that accepted it would overwrite the first byte or emit an extra frame. It times a frame of all-zero bits in both speed modes and straight after a divisor change. A prescaler that kept its old count would stretch the start bit well past the bound. It sends 5-bit characters whose bit 5 is zero, so a serialiser that shifted a full byte would corrupt the stop bit. It receives short characters that must come back zero-filled. It also sends a low stop bit, a half-bit glitch and a frame with reception disabled. A receiver that got any of these wrong would raise `rxc`, set the wrong error flag or change `data_rdata`.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_e;

  // number of data bits for a size code (0..3 -> 5..8)
  function automatic logic [3:0] char_bits(input logic [1:0] sz);
    return 4'd5 + {2'b00, sz};
  endfunction

  // oversampling ticks per bit
  function automatic logic [4:0] os_ticks(input logic dbl);
    return dbl ? 5'd8 : 5'd16;
  endfunction

  // keep only the low bits that belong to a character of the given size
  function automatic logic [CHAR_W-1:0] keep_low(input logic [CHAR_W-1:0] d, input logic [1:0] sz);
    logic [CHAR_W-1:0] m;
    m = 8'hFF >> (2'd3 - sz);
    return d & m;
  endfunction
endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (div_wr) begin
      div_q <= div_val;
      cnt_q <= div_val;
    end else if (cnt_q == '0) begin
      cnt_q <= div_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = (cnt_q == '0) && !div_wr;

  // R7
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0) |=> !tick);
  // R9
  div_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_wr && div_val != '0) |=> !tick);
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_core_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              tx_en,
  input  logic              dbl,
  input  logic [1:0]        sz,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  output logic              txd,
  output logic              dre,
  output logic              load
);
  tx_state_e         st_q;
  logic [CHAR_W-1:0] hold_q, sh_q;
  logic              full_q;
  logic [3:0]        tcnt_q;
  logic [2:0]        bidx_q;
  logic [4:0]        os;
  logic [3:0]        nb;
  logic              accept, bit_end;

  assign os      = os_ticks(dbl);
  assign nb      = char_bits(sz);
  assign accept  = wr && !full_q;
  assign load    = full_q && tx_en && (st_q == TX_IDLE);
  assign bit_end = tick && ({1'b0, tcnt_q} == os - 5'd1);
  assign dre     = !full_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (load) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      hold_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      sh_q   <= '0;
      tcnt_q <= '0;
      bidx_q <= '0;
    end else begin
      if (tick) tcnt_q <= bit_end ? 4'd0 : tcnt_q + 4'd1;
      case (st_q)
        TX_IDLE: if (load) begin
          st_q   <= TX_START;
          sh_q   <= hold_q;
          tcnt_q <= '0;
        end
        TX_START: if (bit_end) begin
          st_q   <= TX_DATA;
          bidx_q <= '0;
        end
        TX_DATA: if (bit_end) begin
          sh_q   <= sh_q >> 1;
          bidx_q <= bidx_q + 3'd1;
          if ({1'b0, bidx_q} == nb - 4'd1) st_q <= TX_STOP;
        end
        TX_STOP: if (bit_end) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh_q[0];
      default:  txd = 1'b1;
    endcase
  end

  // R2
  full_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dre) |=> $stable(hold_q));
  // R3
  load_frees_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> dre);
  // R4
  start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_core_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              dbl,
  input  logic [1:0]        sz,
  input  logic              rxd,
  input  logic              rd,
  output logic [CHAR_W-1:0] rdata,
  output logic              rxc,
  output logic              fe,
  output logic              done
);
  rx_state_e         st_q;
  logic              s1_q, s2_q;
  logic [CHAR_W-1:0] sh_q;
  logic [3:0]        cnt_q;
  logic [2:0]        bidx_q;
  logic [4:0]        os;
  logic [3:0]        nb;
  logic              full_bit, half_bit;

  assign os       = os_ticks(dbl);
  assign nb       = char_bits(sz);
  assign full_bit = tick && ({1'b0, cnt_q} == os - 5'd1);
  assign half_bit = tick && ({1'b0, cnt_q} == (os >> 1) - 5'd1);
  assign done     = (st_q == RX_STOP) && full_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      bidx_q <= '0;
    end else if (!rx_en) begin
      st_q <= RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: if (tick && !s2_q) begin
          st_q  <= RX_START;
          cnt_q <= '0;
        end
        RX_START: if (half_bit) begin
          st_q   <= s2_q ? RX_IDLE : RX_DATA;
          cnt_q  <= '0;
          bidx_q <= '0;
        end else if (tick) cnt_q <= cnt_q + 4'd1;
        RX_DATA: if (full_bit) begin
          sh_q   <= {s2_q, sh_q[CHAR_W-1:1]};
          cnt_q  <= '0;
          bidx_q <= bidx_q + 3'd1;
          if ({1'b0, bidx_q} == nb - 4'd1) st_q <= RX_STOP;
        end else if (tick) cnt_q <= cnt_q + 4'd1;
        RX_STOP: if (full_bit) begin
          st_q  <= s2_q ? RX_IDLE : RX_HOLD;
          cnt_q <= '0;
        end else if (tick) cnt_q <= cnt_q + 4'd1;
        RX_HOLD: if (s2_q) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      rxc   <= 1'b0;
      fe    <= 1'b0;
    end else if (done) begin
      rdata <= sh_q >> (4'd8 - nb);
      rxc   <= 1'b1;
      fe    <= !s2_q;
    end else if (rd) begin
      rxc <= 1'b0;
    end
  end

  // R6
  zero_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((rdata & ~keep_low(8'hFF, $past(sz))) == 8'h00));
  // R10
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> !rxc);
  // R10
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rxc);
  // R11
  stop_low_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !s2_q) |=> fe);
endmodule

// File: rtl/uart_core.sv
module uart_core import uart_core_pkg::*; #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             dbl_speed,
  input  logic [1:0]       char_size,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             data_wr,
  input  logic [7:0]       data_wdata,
  input  logic             data_rd,
  output logic [7:0]       data_rdata,
  output logic             dre,
  output logic             rxc,
  output logic             frame_err,
  input  logic             rxd,
  output logic             txd
);
  logic tick, tx_load, rx_done;

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val), .tick(tick)
  );

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .dbl(dbl_speed),
    .sz(char_size), .wr(data_wr), .wdata(data_wdata), .txd(txd), .dre(dre),
    .load(tx_load)
  );

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_en(rx_en), .dbl(dbl_speed),
    .sz(char_size), .rxd(rxd), .rd(data_rd), .rdata(data_rdata), .rxc(rxc),
    .fe(frame_err), .done(rx_done)
  );

  // R1
  write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !rx_done) |=> $stable(data_rdata));
endmodule

// File: tb/uart_core_test.sv
module uart_core_test;
  logic clk = 0, rst_n = 0;
  logic div_wr = 0, dbl_speed = 0, tx_en = 1, rx_en = 1;
  logic data_wr = 0, data_rd = 0, rxd = 1;
  logic [11:0] div_val = 0;
  logic [1:0] char_size = 3;
  logic [7:0] data_wdata = 0;
  logic [7:0] data_rdata;
  logic dre, rxc, frame_err, txd;
  int errs = 0, checks = 0;
  int cur_p = 16;
  bit done_flag = 0;

  always #10 clk = ~clk;

  uart_core uut (
    .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
    .dbl_speed(dbl_speed), .char_size(char_size), .tx_en(tx_en), .rx_en(rx_en),
    .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd),
    .data_rdata(data_rdata), .dre(dre), .rxc(rxc), .frame_err(frame_err),
    .rxd(rxd), .txd(txd)
  );

  function automatic int nbits(input int sz); return sz + 5; endfunction
  function automatic int cmask(input int sz); return (1 << nbits(sz)) - 1; endfunction
  function automatic int bitp(input int d, input bit dbl); return (dbl ? 8 : 16) * (d + 1); endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic cfg(input int d, input bit dbl, input int sz);
    @(negedge clk);
    div_wr = 1; div_val = d[11:0]; dbl_speed = dbl; char_size = sz[1:0];
    @(negedge clk);
    div_wr = 0;
    cur_p = bitp(d, dbl);
  endtask

  task automatic wr_byte(input logic [7:0] b);
    data_wr = 1; data_wdata = b;
    @(negedge clk);
    data_wr = 0;
  endtask

  task automatic rd_pulse();
    data_rd = 1;
    @(negedge clk);
    data_rd = 0;
    @(negedge clk);
  endtask

  task automatic capture(input int nb, output logic [7:0] b, output logic stopv);
    b = 0;
    while (txd !== 1'b0) @(negedge clk);
    repeat (cur_p + cur_p / 2) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      b[k] = txd;
      repeat (cur_p) @(negedge clk);
    end
    stopv = txd;
  endtask

  task automatic low_len(output int len);
    len = 0;
    while (txd !== 1'b0) @(negedge clk);
    while (txd === 1'b0) begin len++; @(negedge clk); end
  endtask

  task automatic send_rx(input logic [7:0] b, input int nb, input logic stopv);
    rxd = 0;
    repeat (cur_p) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      rxd = b[k];
      repeat (cur_p) @(negedge clk);
    end
    rxd = stopv;
    repeat (cur_p) @(negedge clk);
    rxd = 1;
    if (!stopv) repeat (cur_p) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    logic [7:0] got, b;
    logic stp;
    int len, d, sz, lows;
    bit dbl;
    void'($urandom(32'd20251));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(dre === 1'b1, "R3 reset dre", dre, 1);
    check(rxc === 1'b0, "R10 reset rxc", rxc, 0);
    check(txd === 1'b1, "R4 reset idle line", txd, 1);
    check(data_rdata === 8'h00, "R6 reset rdata", data_rdata, 0);
    check(frame_err === 1'b0, "R11 reset frame_err", frame_err, 0);

    // R7: normal bit period
    cfg(2, 0, 3);
    wr_byte(8'h00);
    low_len(len);
    check(len <= 9 * cur_p && len >= 9 * cur_p - 2, "R7 normal period low time", len, 9 * cur_p);
    repeat (2 * cur_p) @(negedge clk);

    // R4: frame shape, LSB first, high stop
    wr_byte(8'hA5);
    capture(8, got, stp);
    check(got === 8'hA5, "R4 lsb-first data", got, 8'hA5);
    check(stp === 1'b1, "R4 stop bit high", stp, 1);
    repeat (cur_p) @(negedge clk);

    // R5: 5-bit characters ignore upper bits (bit5 of 0x8A is zero)
    cfg(2, 0, 0);
    wr_byte(8'h8A);
    capture(5, got, stp);
    check(got === 8'h0A, "R5 5-bit data", got, 8'h0A);
    check(stp === 1'b1, "R5 stop after 5 bits", stp, 1);
    repeat (cur_p) @(negedge clk);

    // R8: double speed
    cfg(2, 1, 3);
    wr_byte(8'h00);
    low_len(len);
    check(len <= 9 * cur_p && len >= 9 * cur_p - 2, "R8 double-speed low time", len, 9 * cur_p);
    repeat (2 * cur_p) @(negedge clk);

    // R9: divisor reload
    cfg(200, 0, 3);
    repeat (5) @(negedge clk);
    cfg(1, 0, 3);
    wr_byte(8'h00);
    low_len(len);
    check(len <= 9 * cur_p && len >= 9 * cur_p - 1, "R9 reload low time", len, 9 * cur_p);
    repeat (2 * cur_p) @(negedge clk);

    // R3 / R2: disabled transmitter holds byte; second write dropped
    tx_en = 0;
    wr_byte(8'h3C);
    repeat (3 * cur_p) @(negedge clk);
    check(dre === 1'b0, "R3 held while disabled dre", dre, 0);
    check(txd === 1'b1, "R3 line idle while disabled", txd, 1);
    wr_byte(8'hC3);
    tx_en = 1;
    capture(8, got, stp);
    check(got === 8'h3C, "R2 kept first byte", got, 8'h3C);
    check(dre === 1'b1, "R3 dre after load", dre, 1);
    lows = 0;
    repeat (12 * cur_p) begin
      @(negedge clk);
      if (txd === 1'b0) lows++;
    end
    check(lows == 0, "R2 no frame for dropped write", lows, 0);

    // R3: back-to-back via holding register
    wr_byte(8'h81);
    while (dre !== 1'b1) @(negedge clk);
    wr_byte(8'h7E);
    capture(8, got, stp);
    check(got === 8'h81, "R3 first of pair", got, 8'h81);
    capture(8, got, stp);
    check(got === 8'h7E, "R3 second of pair", got, 8'h7E);
    repeat (2 * cur_p) @(negedge clk);

    // R10 / R1: receive, write does not disturb rdata, read clears flag
    cfg(2, 0, 3);
    send_rx(8'h5A, 8, 1);
    check(rxc === 1'b1, "R10 rxc set", rxc, 1);
    check(data_rdata === 8'h5A, "R10 received data", data_rdata, 8'h5A);
    check(frame_err === 1'b0, "R11 good stop", frame_err, 0);
    wr_byte(8'h11);
    @(negedge clk);
    check(data_rdata === 8'h5A, "R1 write keeps rdata", data_rdata, 8'h5A);
    rd_pulse();
    check(rxc === 1'b0, "R10 read clears rxc", rxc, 0);
    repeat (12 * cur_p) @(negedge clk);

    // R11: bad stop bit
    send_rx(8'h33, 8, 0);
    check(rxc === 1'b1 && frame_err === 1'b1, "R11 frame error set", {rxc, frame_err}, 3);
    check(data_rdata === 8'h33, "R11 data with error", data_rdata, 8'h33);
    rd_pulse();
    send_rx(8'h44, 8, 1);
    check(frame_err === 1'b0, "R11 error cleared", frame_err, 0);
    rd_pulse();

    // R12: glitch shorter than half a bit
    rxd = 0;
    repeat (cur_p / 4) @(negedge clk);
    rxd = 1;
    repeat (3 * cur_p) @(negedge clk);
    check(rxc === 1'b0, "R12 glitch no reception", rxc, 0);
    check(data_rdata === 8'h44, "R12 rdata unchanged", data_rdata, 8'h44);

    // R13: receiver disabled
    rx_en = 0;
    send_rx(8'h99, 8, 1);
    check(rxc === 1'b0, "R13 disabled no rxc", rxc, 0);
    check(data_rdata === 8'h44, "R13 disabled rdata", data_rdata, 8'h44);
    rx_en = 1;
    repeat (cur_p) @(negedge clk);

    // R6: 6-bit reception zero-fills
    cfg(2, 0, 1);
    send_rx(8'hFF, 6, 1);
    check(data_rdata === 8'h3F, "R6 6-bit zero fill", data_rdata, 8'h3F);
    rd_pulse();

    // random mix
    for (int it = 0; it < 14; it++) begin
      d = $urandom % 4;
      dbl = 1'($urandom % 2);
      sz = $urandom % 4;
      cfg(d, dbl, sz);
      b = 8'($urandom);
      wr_byte(b);
      capture(nbits(sz), got, stp);
      check(got === 8'(b & cmask(sz)), "R5 random tx", got, b & cmask(sz));
      check(stp === 1'b1, "R4 random stop", stp, 1);
      repeat (cur_p) @(negedge clk);
      b = 8'($urandom);
      send_rx(b, nbits(sz), 1);
      check(rxc === 1'b1, "R10 random rxc", rxc, 1);
      check(data_rdata === 8'(b & cmask(sz)), "R6 random rx", data_rdata, b & cmask(sz));
      rd_pulse();
    end

    done_flag = 1;
    summary();
  end
endmodule